// File: doc/BRIEF.md
# Per-Byte Debug Bus Stealer

This block gives a serial debug channel access to system memory while the processor keeps running. A block command names a start address, a byte count and a direction. The block does not hold the bus for the whole command. It asks for the bus once per byte and releases it as soon as that one access is done. The pace of the serial link sets the pace of the steals.

For a block write, each byte that comes from the serial receiver produces one write cycle on the bus. For a block read, each time the serial transmitter reports that it is empty, the block makes one read cycle. It then hands the fetched byte to the transmitter with a one-cycle valid pulse. The address steps by one after every completed access. The command ends when its byte count is used up.

Commands and received bytes use valid/ready handshakes. A command is taken only in a cycle where `cmd_ready` is high. A received byte is taken only in a cycle where both `rx_valid` and `rx_ready` are high, and the sender must hold the byte until that cycle. On the transmit side, `tx_ready` means the transmitter is empty. `tx_valid` is a one-cycle push that the transmitter cannot stall. The bus request is held until it is granted and is not withdrawn before then.

Top module: `dbg_steal`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_ready` is 1 and `bus_req`, `bus_we`, `rx_ready` and `tx_valid` are 0.
- R2: During a write command, `rx_ready` is high while the block waits for a byte. In the cycle after a byte is taken, `bus_req` and `bus_we` are 1 and `bus_wdata` equals that byte.
- R3: Once raised, `bus_req` stays high with a stable address and direction until a cycle in which `bus_gnt` is 1. That cycle completes the access, and `bus_req` is 0 in the next cycle.
- R4: During a read command, a cycle in which the block waits and `tx_ready` is 1 is followed by `bus_req` = 1 with `bus_we` = 0. The value of `bus_rdata` in the granted cycle appears on `tx_data` in the next cycle, with `tx_valid` high for exactly that one cycle.
- R5: The first access of a command uses `cmd_addr`. Each later access uses the previous address plus one, modulo 2^AW.
- R6: A command with count N performs exactly N accesses. `cmd_ready` returns to 1 in the cycle after the last write is granted, or in the cycle after the last read's `tx_valid` pulse.
- R7: While a command is active, `cmd_ready` is 0 and `cmd_valid` has no effect on addresses, data or count.
- R8: A command whose count is 0 is accepted but produces no bus request, no `rx_ready` and no `tx_valid`.
- R9: `bus_we` is 0 whenever `bus_req` is 0, and `rx_ready` stays 0 throughout a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Block command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_write | input | 1 | 1 = block write, 0 = block read |
| cmd_addr | input | AW | Start address |
| cmd_count | input | CW | Number of bytes |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Block takes the received byte |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Serial transmitter is empty |
| tx_valid | output | 1 | One-cycle load of `tx_data` into the transmitter |
| tx_data | output | 8 | Byte read from memory |
| bus_req | output | 1 | Bus request for one byte access |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_addr | output | AW | Access address |
| bus_we | output | 1 | 1 = write access |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the granted cycle |

## Verification
A corrupted address or remaining count shows up on `bus_addr` at the next access. It also shows up as an early or late return of `cmd_ready` at the end of the command, so a stepping fault is seen on the next granted byte. A wrong sequencer state shows up within one cycle: a request without a pending byte, a request that drops before its grant, a `tx_valid` longer than one cycle, or `rx_ready` during a read. Wrong captured data shows up on `bus_wdata` during the request, or on `tx_data` during the load pulse, and again in the final memory contents.

// File: rtl/dbg_steal_pkg.sv
package dbg_steal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUS  = 2'd2,
    ST_LOAD = 2'd3
  } steal_state_e;
endpackage

// File: rtl/dbg_steal_seq.sv
module dbg_steal_seq
  import dbg_steal_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic         cmd_nonzero,
  input  logic         wr_mode,
  input  logic         last_byte,
  input  logic         none_left,
  input  logic         rx_valid,
  input  logic         tx_ready,
  input  logic         bus_gnt,
  output steal_state_e state,
  output logic         cmd_load,
  output logic         byte_take,
  output logic         access_done
);
  steal_state_e nxt;

  always_comb begin
    cmd_load    = (state == ST_IDLE) && cmd_valid && cmd_nonzero;
    byte_take   = (state == ST_WAIT) && wr_mode && rx_valid;
    access_done = (state == ST_BUS) && bus_gnt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (cmd_load) nxt = ST_WAIT;
      ST_WAIT: begin
        // a write waits for a received byte, a read waits for an empty transmitter
        if (wr_mode ? rx_valid : tx_ready) nxt = ST_BUS;
      end
      ST_BUS: begin
        if (bus_gnt) begin
          if (!wr_mode)       nxt = ST_LOAD;
          else if (last_byte) nxt = ST_IDLE;
          else                nxt = ST_WAIT;
        end
      end
      ST_LOAD: nxt = none_left ? ST_IDLE : ST_WAIT;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dbg_steal_cursor.sv
module dbg_steal_cursor #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          load_write,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_count,
  output logic [AW-1:0] addr,
  output logic          wr_mode,
  output logic          last_byte,
  output logic          none_left
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      remain  <= '0;
      wr_mode <= 1'b0;
    end else if (load) begin
      addr    <= load_addr;
      remain  <= load_count;
      wr_mode <= load_write;
    end else if (step) begin
      addr   <= addr + ADDR_ONE;
      remain <= remain - CNT_ONE;
    end
  end

  assign last_byte = (remain == CNT_ONE);
  assign none_left = (remain == '0);
endmodule

// File: rtl/dbg_steal_lane.sv
module dbg_steal_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_take,
  input  logic [DW-1:0] rx_data,
  input  logic          read_done,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] wbuf,
  output logic [DW-1:0] tbuf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf <= '0;
      tbuf <= '0;
    end else begin
      if (byte_take) wbuf <= rx_data;
      if (read_done) tbuf <= bus_rdata;
    end
  end
endmodule

// File: rtl/dbg_steal.sv
module dbg_steal
  import dbg_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [CW-1:0] cmd_count,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata
);
  localparam int DW = 8;

  steal_state_e state;
  logic cmd_load, byte_take, access_done;
  logic wr_mode, last_byte, none_left;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] wbuf, tbuf;

  dbg_steal_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_nonzero (cmd_count != '0),
    .wr_mode     (wr_mode),
    .last_byte   (last_byte),
    .none_left   (none_left),
    .rx_valid    (rx_valid),
    .tx_ready    (tx_ready),
    .bus_gnt     (bus_gnt),
    .state       (state),
    .cmd_load    (cmd_load),
    .byte_take   (byte_take),
    .access_done (access_done)
  );

  dbg_steal_cursor #(.AW(AW), .CW(CW)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (cmd_load),
    .step       (access_done),
    .load_write (cmd_write),
    .load_addr  (cmd_addr),
    .load_count (cmd_count),
    .addr       (cur_addr),
    .wr_mode    (wr_mode),
    .last_byte  (last_byte),
    .none_left  (none_left)
  );

  dbg_steal_lane #(.DW(DW)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_take (byte_take),
    .rx_data   (rx_data),
    .read_done (access_done && !wr_mode),
    .bus_rdata (bus_rdata),
    .wbuf      (wbuf),
    .tbuf      (tbuf)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign rx_ready  = (state == ST_WAIT) && wr_mode;
  assign bus_req   = (state == ST_BUS);
  assign bus_we    = (state == ST_BUS) && wr_mode;
  assign bus_addr  = cur_addr;
  assign bus_wdata = wbuf;
  assign tx_valid  = (state == ST_LOAD);
  assign tx_data   = tbuf;
endmodule

// File: rtl/dbg_steal_chk.sv
module dbg_steal_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [7:0]    rx_data,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata
);
  p_wr_after_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> bus_req && bus_we && (bus_wdata == $past(rx_data)));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we));

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt |=> !bus_req);

  p_tx_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_gnt && !bus_we |=> tx_valid && (tx_data == $past(bus_rdata)));

  p_tx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || rx_ready || tx_valid) |-> !cmd_ready);

  p_we_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !bus_we);
endmodule

bind dbg_steal dbg_steal_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/dbg_steal_test.sv
module dbg_steal_test;
  localparam int AW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [CW-1:0] cmd_count = '0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          tx_ready = 1'b1;
  logic          gnt_ok = 1'b0;
  logic          cmd_ready, rx_ready, tx_valid, bus_req, bus_we, bus_gnt;
  logic [7:0]    tx_data, bus_wdata, bus_rdata;
  logic [AW-1:0] bus_addr;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];

  assign bus_gnt   = bus_req && gnt_ok;
  assign bus_rdata = mem[bus_addr];

  dbg_steal #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit run_cmp = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 waiting, 2 on bus, 3 loading transmitter
  int m_ph = 0, m_addr = 0, m_cnt = 0, m_wbuf = 0, m_tx = 0;
  bit m_wr = 0;

  always @(posedge clk) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0: if (cmd_valid && cmd_count != 0) begin
             m_wr = cmd_write; m_addr = int'(cmd_addr); m_cnt = int'(cmd_count); m_ph = 1;
           end
        1: if (m_wr && rx_valid) begin m_wbuf = int'(rx_data); m_ph = 2; end
           else if (!m_wr && tx_ready) m_ph = 2;
        2: if (gnt_ok) begin
             if (m_wr) exp_mem[m_addr] = m_wbuf[7:0];
             else      m_tx = int'(exp_mem[m_addr]);
             m_addr = (m_addr + 1) % 256;
             m_cnt--;
             m_ph = !m_wr ? 3 : (m_cnt == 0 ? 0 : 1);
           end
        default: m_ph = (m_cnt == 0) ? 0 : 1;
      endcase
    end
  end

  logic [7:0] rxq [$];
  bit prev_hs = 0;
  int tx_timer = 0;
  int lfsr = 32'h1ACE;

  always @(negedge clk) begin
    cyc++;
    if (prev_hs) void'(rxq.pop_front());
    if (run_cmp) begin
      chk(cmd_ready == (m_ph == 0), "R6/R7 cmd_ready", cmd_ready, m_ph == 0);
      chk(rx_ready == (m_ph == 1 && m_wr), "R2/R9 rx_ready", rx_ready, m_ph == 1 && m_wr);
      chk(bus_req == (m_ph == 2), "R3/R8 bus_req", bus_req, m_ph == 2);
      chk(bus_we == (m_ph == 2 && m_wr), "R9 bus_we", bus_we, m_ph == 2 && m_wr);
      chk(tx_valid == (m_ph == 3), "R4 tx_valid", tx_valid, m_ph == 3);
      if (m_ph == 2) chk(int'(bus_addr) == m_addr, "R5 bus_addr", bus_addr, m_addr);
      if (m_ph == 2 && m_wr) chk(int'(bus_wdata) == m_wbuf, "R2 bus_wdata", bus_wdata, m_wbuf);
      if (m_ph == 3) chk(int'(tx_data) == m_tx, "R4 tx_data", tx_data, m_tx);
    end
    // serial transmitter: busy for a few cycles after each load
    if (tx_valid) begin tx_ready = 1'b0; tx_timer = 3 + (cyc % 4); end
    else if (!tx_ready) begin tx_timer--; if (tx_timer == 0) tx_ready = 1'b1; end
    // receiver: bytes offered with occasional gaps
    rx_valid = (rxq.size() > 0) && (cyc % 5 != 2);
    rx_data  = (rxq.size() > 0) ? rxq[0] : 8'h00;
    prev_hs  = rx_valid && rx_ready;
    // bus arbiter: grant pattern from a small LFSR
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    gnt_ok = lfsr[3] | lfsr[7];
    if (bus_req && gnt_ok && bus_we) mem[bus_addr] = bus_wdata;
  end

  task automatic issue(input bit wr, input int addr, input int cnt);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_write = wr; cmd_addr = AW'(addr); cmd_count = CW'(cnt); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    repeat (2) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    for (int i = 0; i < 256; i++)
      if (mem[i] !== exp_mem[i]) begin
        chk(0, "R2 memory", mem[i], exp_mem[i]);
        break;
      end
    checks++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000) begin
    errors++;
    $display("FAIL R6 watchdog: actual cycles %0d expected below %0d", cyc, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(cmd_ready && !bus_req && !bus_we && !rx_ready && !tx_valid, "R1 reset outputs",
        {cmd_ready, bus_req, bus_we, rx_ready, tx_valid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !bus_req && !tx_valid, "R1 after reset", {cmd_ready, bus_req, tx_valid}, 3'b100);
    run_cmp = 1;
    // R2 R5: block write of four bytes
    rxq.push_back(8'hA1); rxq.push_back(8'hB2); rxq.push_back(8'hC3); rxq.push_back(8'hD4);
    issue(1, 8'h10, 4); wait_done();
    // R4 R6: read them back
    issue(0, 8'h10, 4); wait_done();
    // R5 R7: write across the address wrap, with a stray command while busy
    rxq.push_back(8'h5A); rxq.push_back(8'h6B); rxq.push_back(8'h7C); rxq.push_back(8'h8D);
    issue(1, 8'hFE, 4);
    repeat (3) @(negedge clk);
    cmd_write = 1'b0; cmd_addr = 8'h40; cmd_count = 8'd9; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    wait_done();
    // R8: zero count command, no bus activity
    issue(0, 8'h20, 0);
    repeat (10) @(negedge clk);
    chk(cmd_ready, "R8 idle after zero count", cmd_ready, 1);
    // R4 R5: read across the wrap
    issue(0, 8'hFD, 5); wait_done();
    // R6: single-byte write
    rxq.push_back(8'hEE);
    issue(1, 8'h80, 1); wait_done();
    // R4: long read
    issue(0, 8'h00, 20); wait_done();
    finish_run();
  end
endmodule